// File: doc/BRIEF.md
# Compartment-Aware Peripheral Access Filter

This block sits beside a peripheral bus and decides, for every access, whether the requester may reach the addressed peripheral. Each peripheral entry has its own filter settings. A compartment stage looks at the requester's compartment number. A security stage looks at the requester's secure/non-secure state. A privilege stage looks at its privileged/unprivileged level. The access is granted only when all three stages pass and the entry index is implemented. The decision is combinational: the grant belongs to the same cycle as the request.

Software sets the per-entry settings through a simple word-wide register port, which has a write strobe and a combinational read. A read-only capability word reports three entry counts, and their sum is the number of implemented entries. A compartment entry can also be put in a shared mode. In that mode the fixed compartment number is ignored. A whitelist bitmap names the compartments that may use the peripheral. A companion semaphore block reports, for each entry, whether the semaphore is taken and which compartment holds it.

Top module: `pfw_filter`

## Requirements
- R1: After reset every configuration bit is zero: the security, privilege and compartment words read back as 0, and any in-range index is granted whatever the requester's compartment, security state and privilege.
- R2: Byte address 0xFFC reads the capability word {count_c[7:0] in bits 31:24, count_b[7:0] in bits 23:16, count_a[15:0] in bits 15:0}. Its default is 0x0404_0020. Writes to it have no effect, and the number of implemented entries is count_a+count_b+count_c (40 by default).
- R3: A request whose index is equal to or above the implemented entry count is always denied. The grant is valid in the same cycle as the request.
- R4: Security bits sit at byte address 0x000+4k and privilege bits at 0x040+4k. Entry n is bit n%32 of word n/32. Bits for entries that are not implemented read as zero.
- R5: An entry whose security bit is 1 denies non-secure requests, even when the compartment stage passes, and still grants secure ones.
- R6: An entry whose privilege bit is 1 denies unprivileged requests and still grants privileged ones.
- R7: The compartment word of entry n sits at byte address 0x400+8n. Bit 0 is the filter enable, bit 1 the shared-mode enable, bits 6:4 the fixed compartment and bits 23:16 the whitelist (bit 16+c for compartment c). All other bits, and the word at 0x404+8n, read as zero.
- R8: With the filter enable at 0, every requester compartment passes the compartment stage.
- R9: With the filter enabled, shared mode off and fixed compartment 0, every requester compartment passes.
- R10: With the filter enabled, shared mode off and a non-zero fixed compartment, only a requester with that compartment passes.
- R11: With the filter and shared mode both enabled, the fixed compartment is ignored. The requester passes only if its whitelist bit is set and the semaphore of that entry is held with the owner equal to the requester compartment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte address, for writes and reads |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| chk_idx | input | 8 | Peripheral entry index of the access |
| chk_cid | input | 3 | Requester compartment number |
| chk_secure | input | 1 | Requester is secure |
| chk_priv | input | 1 | Requester is privileged |
| sem_held | input | 40 | Per-entry semaphore taken flag |
| sem_owner | input | 120 | Per-entry semaphore owner compartment, 3 bits each, entry n at bits 3n+2:3n |
| chk_grant | output | 1 | Access granted |

## Verification
Assertions check on every cycle that out-of-range indices, non-secure requests to secure entries, unprivileged requests to privileged entries, and requests with a mismatching fixed compartment are all denied. They also check that any grant in shared mode comes with a semaphore held by the requester, and that reserved compartment-word bits always read as zero. Only the bench scenarios can show the positive cases and the register layout. These are: grants that really happen for whitelisted owners, the packing of entries into security and privilege words, the exact value of the capability word and its refusal of writes, and the reset state seen through reads.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  localparam int CID_W   = 3;
  localparam int NUM_CID = 1 << CID_W;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;

  // compartment word field positions
  localparam int F_FILT = 0;
  localparam int F_SEM  = 1;
  localparam int F_SCID = 4;
  localparam int F_WL   = 16;

  localparam logic [DATA_W-1:0] CID_WORD_MASK = 32'h00FF_0073;

  typedef struct packed {
    logic [NUM_CID-1:0] wl;
    logic [CID_W-1:0]   scid;
    logic               sem_en;
    logic               filt_en;
  } cid_cfg_t;

  function automatic logic [DATA_W-1:0] cid_to_word(cid_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[F_FILT]               = c.filt_en;
    w[F_SEM]                = c.sem_en;
    w[F_SCID +: CID_W]      = c.scid;
    w[F_WL +: NUM_CID]      = c.wl;
    return w;
  endfunction

  function automatic cid_cfg_t word_to_cid(logic [DATA_W-1:0] w);
    cid_cfg_t c;
    c.filt_en = w[F_FILT];
    c.sem_en  = w[F_SEM];
    c.scid    = w[F_SCID +: CID_W];
    c.wl      = w[F_WL +: NUM_CID];
    return c;
  endfunction
endpackage

// File: rtl/pfw_rst_sync.sv
module pfw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pfw_regfile.sv
module pfw_regfile
  import pfw_pkg::*;
#(
  parameter int N_ENT = 40,
  parameter logic [DATA_W-1:0] HW_WORD = 32'h0404_0020
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [N_ENT-1:0]     sec_o,
  output logic [N_ENT-1:0]     priv_o,
  output cid_cfg_t [N_ENT-1:0] cid_o
);
  logic [N_ENT-1:0]     sec_q, sec_d;
  logic [N_ENT-1:0]     priv_q, priv_d;
  cid_cfg_t [N_ENT-1:0] cid_q, cid_d;

  logic       hit_sec, hit_priv, hit_cid, hit_hw;
  logic [3:0] word_sel;
  logic [6:0] ent_sel;

  // address decode
  always_comb begin
    hit_sec  = (addr[11:6] == 6'd0);
    hit_priv = (addr[11:6] == 6'd1);
    hit_cid  = (addr[11:10] == 2'b01) && !addr[2];
    hit_hw   = (addr[11:2] == 10'h3FF);
    word_sel = addr[5:2];
    ent_sel  = addr[9:3];
  end

  logic sec_we, priv_we, cid_we;
  assign sec_we  = wr_en && hit_sec;
  assign priv_we = wr_en && hit_priv;
  assign cid_we  = wr_en && hit_cid;

  // next state
  always_comb begin
    sec_d  = sec_q;
    priv_d = priv_q;
    cid_d  = cid_q;
    for (int e = 0; e < N_ENT; e++) begin
      if (int'(word_sel) == e / 32) begin
        sec_d[e]  = wdata[e % 32];
        priv_d[e] = wdata[e % 32];
      end
      if (int'(ent_sel) == e) cid_d[e] = word_to_cid(wdata);
    end
  end

  // registers, clock enables written out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      priv_q <= '0;
      cid_q  <= '0;
    end else begin
      if (sec_we)  sec_q  <= sec_d;
      if (priv_we) priv_q <= priv_d;
      if (cid_we)  cid_q  <= cid_d;
    end
  end

  // read path
  always_comb begin
    rdata = '0;
    if (hit_hw) begin
      rdata = HW_WORD;
    end else if (hit_sec || hit_priv) begin
      for (int e = 0; e < N_ENT; e++) begin
        if (int'(word_sel) == e / 32)
          rdata[e % 32] = hit_sec ? sec_q[e] : priv_q[e];
      end
    end else if (hit_cid) begin
      for (int e = 0; e < N_ENT; e++) begin
        if (int'(ent_sel) == e) rdata = cid_to_word(cid_q[e]);
      end
    end
  end

  assign sec_o  = sec_q;
  assign priv_o = priv_q;
  assign cid_o  = cid_q;

  // R7: reserved bits of compartment words never read as one
  a_r7_cid_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[11:10] == 2'b01) |-> ((rdata & ~CID_WORD_MASK) == '0));
endmodule

// File: rtl/pfw_cid_stage.sv
module pfw_cid_stage
  import pfw_pkg::*;
(
  input  cid_cfg_t         cfg,
  input  logic [CID_W-1:0] req_cid,
  input  logic             sem_held,
  input  logic [CID_W-1:0] sem_owner,
  output logic             pass
);
  always_comb begin
    if (!cfg.filt_en) begin
      pass = 1'b1;
    end else if (cfg.sem_en) begin
      pass = cfg.wl[req_cid] && sem_held && (sem_owner == req_cid);
    end else if (cfg.scid == '0) begin
      pass = 1'b1;
    end else begin
      pass = (cfg.scid == req_cid);
    end
  end
endmodule

// File: rtl/pfw_check.sv
module pfw_check
  import pfw_pkg::*;
#(
  parameter int N_ENT = 40,
  parameter int IDX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IDX_W-1:0]       idx,
  input  logic [CID_W-1:0]       req_cid,
  input  logic                   req_secure,
  input  logic                   req_priv,
  input  logic [N_ENT-1:0]       sec_cfg,
  input  logic [N_ENT-1:0]       priv_cfg,
  input  cid_cfg_t [N_ENT-1:0]   cid_cfg,
  input  logic [N_ENT-1:0]       sem_held,
  input  logic [N_ENT*CID_W-1:0] sem_owner,
  output logic                   grant
);
  logic [N_ENT-1:0] cid_pass;

  // one compartment stage per entry
  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    pfw_cid_stage u_stage (
      .cfg       (cid_cfg[e]),
      .req_cid   (req_cid),
      .sem_held  (sem_held[e]),
      .sem_owner (sem_owner[e*CID_W +: CID_W]),
      .pass      (cid_pass[e])
    );
  end

  logic             in_range;
  logic             sel_pass, sel_sec, sel_priv, sel_held;
  logic [CID_W-1:0] sel_owner;
  cid_cfg_t         sel_cfg;

  always_comb begin
    in_range  = (int'(idx) < N_ENT);
    sel_pass  = 1'b0;
    sel_sec   = 1'b0;
    sel_priv  = 1'b0;
    sel_held  = 1'b0;
    sel_owner = '0;
    sel_cfg   = '0;
    for (int e = 0; e < N_ENT; e++) begin
      if (int'(idx) == e) begin
        sel_pass  = cid_pass[e];
        sel_sec   = sec_cfg[e];
        sel_priv  = priv_cfg[e];
        sel_held  = sem_held[e];
        sel_owner = sem_owner[e*CID_W +: CID_W];
        sel_cfg   = cid_cfg[e];
      end
    end
    grant = in_range && sel_pass
            && (!sel_sec || req_secure)
            && (!sel_priv || req_priv);
  end

  a_r3_out_of_range_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(idx) >= N_ENT) |-> !grant);

  a_r5_secure_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (in_range && sec_cfg[idx % N_ENT] && !req_secure) |-> !grant);

  a_r6_priv_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (in_range && priv_cfg[idx % N_ENT] && !req_priv) |-> !grant);

  a_r10_static_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (in_range && sel_cfg.filt_en && !sel_cfg.sem_en && (sel_cfg.scid != '0)
     && (sel_cfg.scid != req_cid)) |-> !grant);

  a_r11_sem_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (in_range && sel_cfg.filt_en && sel_cfg.sem_en && grant)
      |-> (sel_held && (sel_owner == req_cid) && sel_cfg.wl[req_cid]));
endmodule

// File: rtl/pfw_filter.sv
module pfw_filter
  import pfw_pkg::*;
#(
  parameter int CNT_A = 32,
  parameter int CNT_B = 4,
  parameter int CNT_C = 4,
  parameter int IDX_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_wr_en,
  input  logic [11:0]                         cfg_addr,
  input  logic [31:0]                         cfg_wdata,
  output logic [31:0]                         cfg_rdata,
  input  logic [IDX_W-1:0]                    chk_idx,
  input  logic [2:0]                          chk_cid,
  input  logic                                chk_secure,
  input  logic                                chk_priv,
  input  logic [CNT_A+CNT_B+CNT_C-1:0]        sem_held,
  input  logic [(CNT_A+CNT_B+CNT_C)*3-1:0]    sem_owner,
  output logic                                chk_grant
);
  localparam int N_ENT = CNT_A + CNT_B + CNT_C;
  localparam logic [31:0] HW_WORD = {8'(CNT_C), 8'(CNT_B), 16'(CNT_A)};

  logic                 rst_n_sync;
  logic [N_ENT-1:0]     sec_cfg, priv_cfg;
  cid_cfg_t [N_ENT-1:0] cid_cfg;

  pfw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pfw_regfile #(.N_ENT(N_ENT), .HW_WORD(HW_WORD)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .wr_en  (cfg_wr_en),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .sec_o  (sec_cfg),
    .priv_o (priv_cfg),
    .cid_o  (cid_cfg)
  );

  pfw_check #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_check (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .idx        (chk_idx),
    .req_cid    (chk_cid),
    .req_secure (chk_secure),
    .req_priv   (chk_priv),
    .sec_cfg    (sec_cfg),
    .priv_cfg   (priv_cfg),
    .cid_cfg    (cid_cfg),
    .sem_held   (sem_held),
    .sem_owner  (sem_owner),
    .grant      (chk_grant)
  );
endmodule

// File: tb/pfw_filter_test.sv
module pfw_filter_test;
  localparam int N = 40;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_wr_en;
  logic [11:0]  cfg_addr;
  logic [31:0]  cfg_wdata;
  logic [31:0]  cfg_rdata;
  logic [7:0]   chk_idx;
  logic [2:0]   chk_cid;
  logic         chk_secure;
  logic         chk_priv;
  logic [N-1:0] sem_held;
  logic [N*3-1:0] sem_owner;
  logic         chk_grant;

  always #5 clk = ~clk;

  pfw_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .chk_idx(chk_idx),
    .chk_cid(chk_cid), .chk_secure(chk_secure), .chk_priv(chk_priv),
    .sem_held(sem_held), .sem_owner(sem_owner), .chk_grant(chk_grant)
  );

  typedef struct packed {
    logic        is_rd;
    logic [31:0] exp;
    logic [7:0]  req;
  } item_t;

  item_t queue_q[$];
  event  ev_sample;
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(ev_sample);
      #1;
      if (queue_q.size() != 0) begin
        item_t it;
        logic [31:0] act;
        it  = queue_q.pop_front();
        act = it.is_rd ? cfg_rdata : {31'd0, chk_grant};
        n_tests++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL R%0d actual=0x%08h expected=0x%08h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr_en = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic exp_rd(input logic [11:0] a, input logic [31:0] e, input int r);
    @(negedge clk);
    cfg_addr = a;
    #1;
    queue_q.push_back('{is_rd: 1'b1, exp: e, req: 8'(r)});
    -> ev_sample;
  endtask

  task automatic exp_acc(input int idx, input int cid, input logic s, input logic p,
                         input logic e, input int r);
    @(negedge clk);
    chk_idx = 8'(idx); chk_cid = 3'(cid); chk_secure = s; chk_priv = p;
    #1;
    queue_q.push_back('{is_rd: 1'b0, exp: {31'd0, e}, req: 8'(r)});
    -> ev_sample;
  endtask

  task automatic set_sem(input int ent, input logic held, input int owner);
    sem_held[ent] = held;
    sem_owner[ent*3 +: 3] = 3'(owner);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    chk_idx = '0; chk_cid = '0; chk_secure = 1'b0; chk_priv = 1'b0;
    sem_held = '0; sem_owner = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state
    exp_rd(12'h000, 32'h0, 1);
    exp_rd(12'h040, 32'h0, 1);
    exp_rd(12'h428, 32'h0, 1);
    exp_acc(3, 5, 1'b0, 1'b0, 1'b1, 1);
    exp_acc(39, 7, 1'b1, 1'b1, 1'b1, 1);

    // R2: capability word, read only
    exp_rd(12'hFFC, 32'h0404_0020, 2);
    wr(12'hFFC, 32'h0);
    exp_rd(12'hFFC, 32'h0404_0020, 2);

    // R3: range limit
    exp_acc(40, 0, 1'b1, 1'b1, 1'b0, 3);
    exp_acc(255, 1, 1'b1, 1'b1, 1'b0, 3);
    exp_acc(39, 1, 1'b0, 1'b0, 1'b1, 3);

    // R4 / R5: security packing, entry 39 = word1 bit7
    wr(12'h004, 32'hFFFF_FFFF);
    exp_rd(12'h004, 32'h0000_00FF, 4);
    wr(12'h004, 32'h0000_0080);
    exp_acc(39, 0, 1'b0, 1'b1, 1'b0, 5);
    exp_acc(39, 0, 1'b1, 1'b0, 1'b1, 5);
    exp_acc(38, 0, 1'b0, 1'b0, 1'b1, 4);

    // R6 / R4: privilege, entry 2 = word0 bit2
    wr(12'h040, 32'h0000_0004);
    exp_rd(12'h040, 32'h0000_0004, 4);
    exp_acc(2, 0, 1'b1, 1'b0, 1'b0, 6);
    exp_acc(2, 0, 1'b1, 1'b1, 1'b1, 6);
    exp_acc(3, 0, 1'b1, 1'b0, 1'b1, 6);

    // R7: compartment word layout, entry 10 at 0x450
    wr(12'h450, 32'hFFFF_FFFF);
    exp_rd(12'h450, 32'h00FF_0073, 7);
    exp_rd(12'h454, 32'h0, 7);

    // R10: fixed compartment 3
    wr(12'h450, 32'h0000_0031);
    exp_acc(10, 3, 1'b0, 1'b0, 1'b1, 10);
    exp_acc(10, 4, 1'b0, 1'b0, 1'b0, 10);
    // R9: fixed compartment 0 lets everyone through
    wr(12'h450, 32'h0000_0001);
    exp_acc(10, 6, 1'b0, 1'b0, 1'b1, 9);
    // R8: filter off, fixed value ignored
    wr(12'h450, 32'h0000_0050);
    exp_acc(10, 2, 1'b0, 1'b0, 1'b1, 8);

    // R11: shared mode, entry 11 at 0x458, fixed 2, whitelist {5}
    wr(12'h458, 32'h0020_0023);
    set_sem(11, 1'b1, 5);
    exp_acc(11, 5, 1'b0, 1'b0, 1'b1, 11);
    exp_acc(11, 2, 1'b0, 1'b0, 1'b0, 11);
    set_sem(11, 1'b0, 5);
    exp_acc(11, 5, 1'b0, 1'b0, 1'b0, 11);
    set_sem(11, 1'b1, 4);
    exp_acc(11, 5, 1'b0, 1'b0, 1'b0, 11);
    exp_acc(11, 4, 1'b0, 1'b0, 1'b0, 11);
    wr(12'h458, 32'h0030_0023);
    exp_acc(11, 4, 1'b0, 1'b0, 1'b1, 11);

    // R5: security still applies after a passing shared-mode stage
    wr(12'h000, 32'h0000_0800);
    exp_acc(11, 4, 1'b0, 1'b0, 1'b0, 5);
    exp_acc(11, 4, 1'b1, 1'b0, 1'b1, 5);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule